// File: doc/BRIEF.md
# Synchronization Symbol Locator

This block tracks where the receiver currently sits inside a 10 ms radio frame. It keeps a slot counter and an OFDM symbol counter, and it raises registered strobes on the symbols that carry the primary and the secondary synchronization signals. A symbol-rate tick moves the position forward by one symbol. A frame-start pulse realigns the position to the start of the frame. Duplex mode and cyclic-prefix length are chosen by two select inputs. These selects are captured only when the frame-start pulse arrives, so a frame is always decoded under one configuration.

Downstream correlators and detectors use the strobes to open their windows. The block does not produce or detect any sequence samples. It only marks the time positions. The half-frame output tells a consumer which of the two identical synchronization occasions in the frame is current.

Top module: `sync_symbol_locator`

## Requirements
- R1: While rst_ni is low, and after its release until the first tick or frame start, slot_o and symbol_o are 0, pss_o, sss_o and half_frame_o are 0, and the latched configuration is FDD with normal cyclic prefix.
- R2: Each cycle with sym_tick_i high and frame_start_i low advances symbol_o by one. After the last symbol of a slot (index 6 with normal prefix, index 5 with extended prefix), symbol_o returns to 0 and slot_o increments. Without a tick, the position holds.
- R3: slot_o counts 0 to 19 and wraps from 19 to 0 on the tick that ends slot 19.
- R4: A cycle with frame_start_i high sets slot_o and symbol_o to 0 and latches tdd_mode_i and ext_cp_i. It takes precedence over a simultaneous tick.
- R5: Changes on tdd_mode_i (1 = TDD, 0 = FDD) or ext_cp_i (1 = extended, 0 = normal) have no effect on the counting or the strobes until the next frame start.
- R6: In FDD mode, pss_o is high exactly while the position is the last symbol of slot 0 or of slot 10.
- R7: In FDD mode, sss_o is high exactly while the position is the second-to-last symbol of slot 0 or of slot 10.
- R8: In TDD mode, pss_o is high exactly while the position is symbol 2 of slot 2 or of slot 12.
- R9: In TDD mode, sss_o is high exactly while the position is the last symbol of slot 1 or of slot 11.
- R10: half_frame_o is 0 while slot_o is 0 to 9 and 1 while slot_o is 10 to 19.
- R11: The strobes come from registers that change in the same cycle as slot_o and symbol_o, and pss_o and sss_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_tick_i | input | 1 | One-cycle pulse per OFDM symbol |
| frame_start_i | input | 1 | One-cycle pulse marking the start of a radio frame |
| tdd_mode_i | input | 1 | Duplex select: 1 = TDD, 0 = FDD |
| ext_cp_i | input | 1 | Prefix select: 1 = extended, 0 = normal |
| slot_o | output | 5 | Current slot index, 0 to 19 |
| symbol_o | output | 3 | Current symbol index within the slot |
| pss_o | output | 1 | High on a primary synchronization symbol |
| sss_o | output | 1 | High on a secondary synchronization symbol |
| half_frame_o | output | 1 | 0 for the first half-frame, 1 for the second |

## Verification
The assertions take for granted that sym_tick_i and frame_start_i are single-cycle pulses, that the tick rate is far below the clock rate, and that the selects are meaningful only at frame start. The FDD ordering property assumes that a tick moves the position exactly one symbol with no frame start in between. The stimulus follows these assumptions. Every tick is a one-cycle pulse followed by an idle cycle, and frame starts are issued either alone or together with a tick, which is the case where precedence matters. All four duplex and prefix combinations are swept over a full frame plus a wrap, with select changes injected in the middle of a frame.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
  typedef struct packed {
    logic tdd;
    logic ext;
  } ssl_cfg_t;

  localparam ssl_cfg_t SSL_CFG_RST = '{tdd: 1'b0, ext: 1'b0};
endpackage

// File: rtl/ssl_frame_counter.sv
module ssl_frame_counter
  import ssl_pkg::*;
#(
  parameter int SLOTS     = 20,
  parameter int NSYM_NORM = 7,
  parameter int NSYM_EXT  = 6,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int SYM_W    = $clog2(NSYM_NORM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              frame_start_i,
  input  ssl_cfg_t          cfg_i,
  output logic [SLOT_W-1:0] slot_q_o,
  output logic [SYM_W-1:0]  sym_q_o,
  output ssl_cfg_t          cfg_q_o,
  output logic [SLOT_W-1:0] slot_d_o,
  output logic [SYM_W-1:0]  sym_d_o,
  output ssl_cfg_t          cfg_d_o
);
  localparam logic [SYM_W-1:0]  LAST_NORM = SYM_W'(NSYM_NORM - 1);
  localparam logic [SYM_W-1:0]  LAST_EXT  = SYM_W'(NSYM_EXT - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [SYM_W-1:0]  sym_q, sym_d;
  ssl_cfg_t          cfg_q, cfg_d;
  logic [SYM_W-1:0]  last_sym;

  assign last_sym = cfg_q.ext ? LAST_EXT : LAST_NORM;

  always_comb begin
    slot_d = slot_q;
    sym_d  = sym_q;
    cfg_d  = cfg_q;
    if (frame_start_i) begin
      slot_d = '0;
      sym_d  = '0;
      cfg_d  = cfg_i;
    end else if (tick_i) begin
      if (sym_q == last_sym) begin
        sym_d  = '0;
        slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end else begin
        sym_d = sym_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      sym_q  <= '0;
      cfg_q  <= SSL_CFG_RST;
    end else begin
      slot_q <= slot_d;
      sym_q  <= sym_d;
      cfg_q  <= cfg_d;
    end
  end

  assign slot_q_o = slot_q;
  assign sym_q_o  = sym_q;
  assign cfg_q_o  = cfg_q;
  assign slot_d_o = slot_d;
  assign sym_d_o  = sym_d;
  assign cfg_d_o  = cfg_d;

  assert_slot_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(slot_q) < SLOTS);
  assert_sym_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_q <= last_sym);
  assert_hold_no_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !frame_start_i) |=> ($stable(slot_q) && $stable(sym_q)));
  assert_frame_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> (slot_q == '0 && sym_q == '0));
  assert_cfg_frozen_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start_i |=> $stable(cfg_q));
endmodule

// File: rtl/ssl_sync_decoder.sv
module ssl_sync_decoder
  import ssl_pkg::*;
#(
  parameter int SLOTS        = 20,
  parameter int NSYM_NORM    = 7,
  parameter int NSYM_EXT     = 6,
  parameter int TDD_SSS_SLOT = 1,
  parameter int TDD_PSS_SLOT = 2,
  parameter int TDD_PSS_SYM  = 2,
  localparam int SLOT_W      = $clog2(SLOTS),
  localparam int SYM_W       = $clog2(NSYM_NORM)
) (
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SYM_W-1:0]  sym_i,
  input  ssl_cfg_t          cfg_i,
  output logic              pss_o,
  output logic              sss_o
);
  localparam int HALF = SLOTS / 2;
  localparam logic [SLOT_W-1:0] HALF_W    = SLOT_W'(HALF);
  localparam logic [SYM_W-1:0]  LAST_NORM = SYM_W'(NSYM_NORM - 1);
  localparam logic [SYM_W-1:0]  LAST_EXT  = SYM_W'(NSYM_EXT - 1);

  logic [SLOT_W-1:0] rel_slot;
  logic [SYM_W-1:0]  last_sym;

  // Both half-frames carry the same pattern, so decode relative to the half
  assign rel_slot = (slot_i >= HALF_W) ? slot_i - HALF_W : slot_i;
  assign last_sym = cfg_i.ext ? LAST_EXT : LAST_NORM;

  always_comb begin
    if (cfg_i.tdd) begin
      pss_o = (rel_slot == SLOT_W'(TDD_PSS_SLOT)) && (sym_i == SYM_W'(TDD_PSS_SYM));
      sss_o = (rel_slot == SLOT_W'(TDD_SSS_SLOT)) && (sym_i == last_sym);
    end else begin
      pss_o = (rel_slot == '0) && (sym_i == last_sym);
      sss_o = (rel_slot == '0) && (sym_i == last_sym - 1'b1);
    end
  end
endmodule

// File: rtl/sync_symbol_locator.sv
module sync_symbol_locator
  import ssl_pkg::*;
#(
  parameter int SLOTS     = 20,
  parameter int NSYM_NORM = 7,
  parameter int NSYM_EXT  = 6,
  localparam int SLOT_W   = $clog2(SLOTS),
  localparam int SYM_W    = $clog2(NSYM_NORM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sym_tick_i,
  input  logic              frame_start_i,
  input  logic              tdd_mode_i,
  input  logic              ext_cp_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SYM_W-1:0]  symbol_o,
  output logic              pss_o,
  output logic              sss_o,
  output logic              half_frame_o
);
  localparam logic [SLOT_W-1:0] HALF_W = SLOT_W'(SLOTS / 2);

  ssl_cfg_t          cfg_in, cfg_q, cfg_d;
  logic [SLOT_W-1:0] slot_d;
  logic [SYM_W-1:0]  sym_d;
  logic              pss_d, sss_d, pss_q, sss_q;

  assign cfg_in = '{tdd: tdd_mode_i, ext: ext_cp_i};

  ssl_frame_counter #(.SLOTS(SLOTS), .NSYM_NORM(NSYM_NORM), .NSYM_EXT(NSYM_EXT)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i(sym_tick_i), .frame_start_i,
    .cfg_i(cfg_in),
    .slot_q_o(slot_o), .sym_q_o(symbol_o), .cfg_q_o(cfg_q),
    .slot_d_o(slot_d), .sym_d_o(sym_d), .cfg_d_o(cfg_d)
  );

  // Decode the upcoming position so registered strobes line up with the counters
  ssl_sync_decoder #(.SLOTS(SLOTS), .NSYM_NORM(NSYM_NORM), .NSYM_EXT(NSYM_EXT)) u_dec (
    .slot_i(slot_d), .sym_i(sym_d), .cfg_i(cfg_d),
    .pss_o(pss_d), .sss_o(sss_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pss_q <= 1'b0;
      sss_q <= 1'b0;
    end else begin
      pss_q <= pss_d;
      sss_q <= sss_d;
    end
  end

  assign pss_o        = pss_q;
  assign sss_o        = sss_q;
  assign half_frame_o = (slot_o >= HALF_W);

  assert_strobe_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pss_o && sss_o));
  assert_fdd_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.tdd && sss_o && sym_tick_i && !frame_start_i) |=> pss_o);
  assert_tdd_pss_sym_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.tdd && pss_o) |-> (symbol_o == SYM_W'(2)));
  assert_fdd_pss_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q.tdd && pss_o) |-> (slot_o == '0 || slot_o == HALF_W));
endmodule

// File: tb/sync_symbol_locator_bench.sv
module sync_symbol_locator_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, fs = 1'b0, tdd_in = 1'b0, ext_in = 1'b0;
  logic [4:0] slot;
  logic [2:0] sym;
  logic pss, sss, half;
  int ncmp = 0, nbad = 0;
  int m_slot = 0, m_sym = 0;
  bit m_tdd = 0, m_ext = 0, done = 0;

  always #10 clk = ~clk;

  sync_symbol_locator u_sync_symbol_locator (
    .clk_i(clk), .rst_ni(rst_n), .sym_tick_i(tick), .frame_start_i(fs),
    .tdd_mode_i(tdd_in), .ext_cp_i(ext_in),
    .slot_o(slot), .symbol_o(sym), .pss_o(pss), .sss_o(sss), .half_frame_o(half));

  task automatic chk(string tag, int act, int exp);
    ncmp++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d (slot %0d sym %0d)", tag, act, exp, m_slot, m_sym);
    end
  endtask

  function automatic int last_sym();
    return m_ext ? 5 : 6;
  endfunction
  function automatic int exp_pss();
    int rel = m_slot % 10;
    if (m_tdd) return int'(rel == 2 && m_sym == 2);
    return int'(rel == 0 && m_sym == last_sym());
  endfunction
  function automatic int exp_sss();
    int rel = m_slot % 10;
    if (m_tdd) return int'(rel == 1 && m_sym == last_sym());
    return int'(rel == 0 && m_sym == last_sym() - 1);
  endfunction

  task automatic chk_all();
    chk("R2 symbol", int'(sym), m_sym);
    chk("R3 slot", int'(slot), m_slot);
    chk("R10 half_frame", int'(half), int'(m_slot >= 10));
    chk(m_tdd ? "R8 pss" : "R6 pss", int'(pss), exp_pss());
    chk(m_tdd ? "R9 sss" : "R7 sss", int'(sss), exp_sss());
    chk("R11 exclusive", int'(pss && sss), 0);
  endtask

  task automatic step(bit t, bit f);
    @(negedge clk);
    tick = t; fs = f;
    @(posedge clk);
    if (f) begin
      m_slot = 0; m_sym = 0; m_tdd = tdd_in; m_ext = ext_in;
    end else if (t) begin
      if (m_sym == last_sym()) begin
        m_sym = 0;
        m_slot = (m_slot == 19) ? 0 : m_slot + 1;
      end else m_sym++;
    end
    @(negedge clk);
    tick = 1'b0; fs = 1'b0;
    chk_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 slot", int'(slot), 0);
    chk("R1 symbol", int'(sym), 0);
    chk("R1 strobes", int'({pss, sss, half}), 0);
    rst_n = 1'b1;
    step(0, 0);
    chk("R1 idle slot", int'(slot), 0);
    // R1: default config is FDD normal, so slot 0 sym 6 is a PSS position
    for (int i = 0; i < 6; i++) step(1, 0);
    chk("R1 default cfg pss", int'(pss), 1);

    for (int c = 0; c < 4; c++) begin
      tdd_in = c[0]; ext_in = c[1];
      step(0, 1);
      chk("R4 slot", int'(slot), 0);
      for (int i = 0; i < 20 * 7 + 15; i++) step(1, 0);
    end

    // R5: selects flip mid-frame, latched FDD normal must persist
    tdd_in = 0; ext_in = 0;
    step(0, 1);
    for (int i = 0; i < 30; i++) step(1, 0);
    tdd_in = 1; ext_in = 1;
    for (int i = 0; i < 130; i++) begin
      step(1, 0);
      chk("R5 pss", int'(pss), exp_pss());
      chk("R5 symbol", int'(sym), m_sym);
    end

    // R4: frame start wins over a simultaneous tick, and latches TDD extended
    for (int i = 0; i < 9; i++) step(1, 0);
    step(1, 1);
    chk("R4 slot", int'(slot), 0);
    chk("R4 symbol", int'(sym), 0);
    for (int i = 0; i < 20 * 6 + 4; i++) step(1, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      ncmp++; nbad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end
endmodule